// File: doc/BRIEF.md
# Receiver Interrupt Aggregator with Hold

This block sits behind the status-detection logic of a digital audio interface receiver. It gathers eight event indications into one status word and drives two interrupt lines from that word. Three of the events are transient. They are kept as sticky bits until software reads the status word. The remaining five are live levels that the status word follows one cycle late.

Each interrupt line has its own eight-bit enable register. A line goes high when any enabled status bit is set. The held line stays high after its events have gone away, for a programmable number of sample-rate ticks. The direct line drops in the same cycle that its last enabled event clears. When the clock-mode input selects PLL off, both lines are held low and the hold timer is emptied.

Top module: `rxirq_aggregator`

## Requirements
- R1: After reset, `status` is 0 and both interrupt lines are low. The held-line enable register is 0x03 and the direct-line enable register is 0x1C. The hold field is 01.
- R2: The status bit map is: bit0 lock lost, bit1 parity/biphase error, bit2 non-PCM, bit3 DTS-CD, bit4 audio bit, bit5 pre-emphasis bit, bit6 Q-subcode change, bit7 channel-status change. Bits 0, 2 and 3 take the value of their input at each clock edge.
- R3: Bits 1, 6 and 7 are set by a one-cycle pulse. Each stays 1 until a cycle with `status_rd` high, which clears it. A pulse that arrives in the same cycle as the read leaves the bit set.
- R4: Bits 4 and 5 sample `audio_bit` and `preemph_bit` at each edge where `lock_lost` is 0. In cycles where `lock_lost` is 1, bits 4 and 5 keep their value, and pulses on `qsub_chg_p` or `cstat_chg_p` are ignored.
- R5: The enable registers only gate the interrupt lines. Writing them never changes `status`.
- R6: `int_direct` is high exactly when a status bit whose direct-line enable bit is set is 1. It goes low in the cycle that condition ends.
- R7: `int_hold` is high while a status bit whose held-line enable bit is set is 1. After the last such cycle, it stays high until N `fs_tick` strobes have been counted at later clock edges, with N = 512 << hold. Hold codes 00/01/10/11 give 512/1024/2048/4096.
- R8: If an enabled event returns during the hold period, the hold count restarts from its full length.
- R9: When `clk_mode` equals 2'b01, both lines are low and the hold count is cleared. The status bits are not affected.
- R10: At each edge, `en_hold_we` loads `cfg_wdata` into the held-line enable register, `en_direct_we` loads `cfg_wdata` into the direct-line enable register, and `hold_we` loads `cfg_wdata[1:0]` into the hold field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| clk_mode | input | 2 | Clock mode; 2'b01 means PLL off |
| lock_lost | input | 1 | PLL lock lost (level) |
| par_err_p | input | 1 | Parity or biphase error pulse |
| nonpcm_det | input | 1 | Non-PCM stream detected (level) |
| dtscd_det | input | 1 | DTS-CD stream detected (level) |
| audio_bit | input | 1 | Recovered audio bit (level) |
| preemph_bit | input | 1 | Recovered pre-emphasis bit (level) |
| qsub_chg_p | input | 1 | Q-subcode changed pulse |
| cstat_chg_p | input | 1 | Channel-status changed pulse |
| en_hold_we | input | 1 | Write strobe for held-line enables |
| en_direct_we | input | 1 | Write strobe for direct-line enables |
| hold_we | input | 1 | Write strobe for hold field |
| cfg_wdata | input | 8 | Configuration write data |
| status_rd | input | 1 | Status read strobe; clears sticky bits |
| status | output | 8 | Status word |
| int_hold | output | 1 | Interrupt line with hold |
| int_direct | output | 1 | Interrupt line without hold |

## Verification
The assertions assume that every input is a defined 0 or 1 from the first edge after reset, since several properties compare against `$past` of an input. They also assume that `fs_tick` is the only thing that can advance the hold count, so a fall of `int_hold` outside PLL-off mode follows a tick. The bench drives every input to 0 during reset and changes inputs only on the falling clock edge. It draws the random event, tick, read and mode values from a seeded generator, and keeps pulse inputs to single cycles.

// File: rtl/rxirq_pkg.sv
// Package: shared event indices, widths and encodings for the receiver
// interrupt aggregator. Assumes a fixed set of eight event sources.
package rxirq_pkg;
    localparam int EVT_N = 8;
    localparam int HOLD_W = 2;

    typedef logic [EVT_N-1:0] evt_vec_t;

    // Bit positions in the status word (decoded by software).
    typedef enum int {
        EV_UNLOCK  = 0,
        EV_PARITY  = 1,
        EV_NONPCM  = 2,
        EV_DTSCD   = 3,
        EV_AUDIO   = 4,
        EV_PREEMPH = 5,
        EV_QSUB    = 6,
        EV_CSTAT   = 7
    } evt_idx_e;

    localparam logic [1:0] CM_PLL_OFF = 2'b01;
    localparam evt_vec_t EN_HOLD_RST = 8'b0000_0011;
    localparam evt_vec_t EN_DIRECT_RST = 8'b0001_1100;
    localparam logic [HOLD_W-1:0] HOLD_RST = 2'b01;
endpackage

// File: rtl/rxirq_status.sv
// Status word register. Live bits follow their inputs one cycle late.
// Channel-status derived bits freeze while lock is lost. Sticky bits
// set on pulses and clear on a read strobe; a same-cycle pulse wins.
// Assumes pulse inputs are one cycle wide and synchronous to clk.
module rxirq_status
    import rxirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lock_lost,
    input  logic     par_err_p,
    input  logic     nonpcm_det,
    input  logic     dtscd_det,
    input  logic     audio_bit,
    input  logic     preemph_bit,
    input  logic     qsub_chg_p,
    input  logic     cstat_chg_p,
    input  logic     status_rd,
    output evt_vec_t status
);
    evt_vec_t stat_q;
    evt_vec_t stat_d;
    logic     cs_upd;

    // Next value of a sticky bit: hold unless read, then OR in the new event.
    function automatic logic sticky_next(input logic cur, input logic rd, input logic ev);
        return (cur & ~rd) | ev;
    endfunction

    // Channel-status derived bits update only while lock is held.
    assign cs_upd = ~lock_lost;

    // Compute the next status word from inputs and the current word.
    always_comb begin
        stat_d              = stat_q;
        stat_d[EV_UNLOCK]   = lock_lost;
        stat_d[EV_NONPCM]   = nonpcm_det;
        stat_d[EV_DTSCD]    = dtscd_det;
        if (cs_upd) begin
            stat_d[EV_AUDIO]   = audio_bit;
            stat_d[EV_PREEMPH] = preemph_bit;
        end
        stat_d[EV_PARITY] = sticky_next(stat_q[EV_PARITY], status_rd, par_err_p);
        stat_d[EV_QSUB]   = sticky_next(stat_q[EV_QSUB], status_rd, qsub_chg_p & cs_upd);
        stat_d[EV_CSTAT]  = sticky_next(stat_q[EV_CSTAT], status_rd, cstat_chg_p & cs_upd);
    end

    // Register the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/rxirq_cfg.sv
// Configuration registers: one enable vector per interrupt line and the
// hold-length code. Assumes write strobes are synchronous single cycles.
module rxirq_cfg
    import rxirq_pkg::*;
#(
    parameter int OUT_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OUT_N-1:0]  en_we,
    input  logic              hold_we,
    input  evt_vec_t          wdata,
    output evt_vec_t          en_q [OUT_N],
    output logic [HOLD_W-1:0] hold_q
);
    // Reset value for enable register k.
    function automatic evt_vec_t en_reset(input int k);
        return (k == 0) ? EN_HOLD_RST : EN_DIRECT_RST;
    endfunction

    for (genvar k = 0; k < OUT_N; k++) begin : g_en
        // Load enable register k on its write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[k] <= en_reset(k);
            end else if (en_we[k]) begin
                en_q[k] <= wdata;
            end
        end
    end

    // Load the hold-length code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= HOLD_RST;
        end else if (hold_we) begin
            hold_q <= wdata[HOLD_W-1:0];
        end
    end
endmodule

// File: rtl/rxirq_route.sv
// Masks the status word with an enable vector and ORs the result.
// Purely combinational; assumes registered inputs.
module rxirq_route
    import rxirq_pkg::*;
(
    input  evt_vec_t status,
    input  evt_vec_t enable,
    output logic     active
);
    // Reduce the enabled events to one activity flag.
    assign active = |(status & enable);
endmodule

// File: rtl/rxirq_hold.sv
// Hold timer for the stretched interrupt line. It reloads to the full
// length while the line's events are active, and counts down on fs_tick
// after they clear. It is emptied while force_off is high. The length is
// BASE_LEN << hold_sel. Assumes fs_tick is a single-cycle strobe.
module rxirq_hold
    import rxirq_pkg::*;
#(
    parameter int BASE_LEN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_tick,
    input  logic              force_off,
    input  logic              active,
    input  logic [HOLD_W-1:0] hold_sel,
    output logic              irq
);
    localparam int MAX_LEN = BASE_LEN << ((1 << HOLD_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full_len;

    // Decode the hold code into a tick count.
    always_comb begin
        full_len = CNT_W'(BASE_LEN) << hold_sel;
    end

    // Reload, count down, or clear the hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (force_off) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= full_len;
        end else if (fs_tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Line is high while events are active or the hold is running.
    assign irq = ~force_off & (active | (cnt_q != '0));
endmodule

// File: rtl/rxirq_aggregator.sv
// Receiver interrupt aggregator. It collects eight receiver events into a
// status word and drives a held interrupt line and a direct one, each
// with its own enable vector. Assumes all inputs are synchronous to clk.
module rxirq_aggregator
    import rxirq_pkg::*;
#(
    parameter int BASE_LEN = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fs_tick,
    input  logic [1:0] clk_mode,
    input  logic       lock_lost,
    input  logic       par_err_p,
    input  logic       nonpcm_det,
    input  logic       dtscd_det,
    input  logic       audio_bit,
    input  logic       preemph_bit,
    input  logic       qsub_chg_p,
    input  logic       cstat_chg_p,
    input  logic       en_hold_we,
    input  logic       en_direct_we,
    input  logic       hold_we,
    input  logic [7:0] cfg_wdata,
    input  logic       status_rd,
    output logic [7:0] status,
    output logic       int_hold,
    output logic       int_direct
);
    localparam int OUT_N = 2;
    localparam int O_HOLD = 0;
    localparam int O_DIRECT = 1;

    evt_vec_t          stat_w;
    evt_vec_t          en_w [OUT_N];
    logic [HOLD_W-1:0] hold_w;
    logic [OUT_N-1:0]  act_w;
    logic              pll_off;

    // PLL-off mode forces both lines low.
    assign pll_off = (clk_mode == CM_PLL_OFF);

    rxirq_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_lost   (lock_lost),
        .par_err_p   (par_err_p),
        .nonpcm_det  (nonpcm_det),
        .dtscd_det   (dtscd_det),
        .audio_bit   (audio_bit),
        .preemph_bit (preemph_bit),
        .qsub_chg_p  (qsub_chg_p),
        .cstat_chg_p (cstat_chg_p),
        .status_rd   (status_rd),
        .status      (stat_w)
    );

    rxirq_cfg #(.OUT_N(OUT_N)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   ({en_direct_we, en_hold_we}),
        .hold_we (hold_we),
        .wdata   (cfg_wdata),
        .en_q    (en_w),
        .hold_q  (hold_w)
    );

    for (genvar k = 0; k < OUT_N; k++) begin : g_route
        rxirq_route u_route (
            .status (stat_w),
            .enable (en_w[k]),
            .active (act_w[k])
        );
    end

    rxirq_hold #(.BASE_LEN(BASE_LEN)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_tick   (fs_tick),
        .force_off (pll_off),
        .active    (act_w[O_HOLD]),
        .hold_sel  (hold_w),
        .irq       (int_hold)
    );

    // Direct line has no hold: it follows its enabled events.
    assign int_direct = act_w[O_DIRECT] & ~pll_off;
    assign status     = stat_w;
endmodule

// Checker: temporal properties of the aggregator at its ports.
module rxirq_aggregator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fs_tick,
    input logic [1:0] clk_mode,
    input logic       lock_lost,
    input logic       par_err_p,
    input logic       status_rd,
    input logic [7:0] status,
    input logic       int_hold,
    input logic       int_direct
);
    // R9
    pll_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode == 2'b01) |-> (!int_hold && !int_direct));

    // R2
    unlock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[0] == $past(lock_lost)));

    // R3
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !status_rd) |=> status[1]);

    // R3
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !par_err_p) |=> !status[1]);

    // R4
    cs_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |=> (status[5:4] == $past(status[5:4])));

    // R7
    hold_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_hold) && clk_mode != 2'b01 && $past(clk_mode) != 2'b01
         && $past(status) == status) |-> $past(fs_tick));
endmodule

bind rxirq_aggregator rxirq_aggregator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_tick    (fs_tick),
    .clk_mode   (clk_mode),
    .lock_lost  (lock_lost),
    .par_err_p  (par_err_p),
    .status_rd  (status_rd),
    .status     (status),
    .int_hold   (int_hold),
    .int_direct (int_direct)
);

// File: tb/test_rxirq_aggregator.sv
module test_rxirq_aggregator;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fs_tick, lock_lost, par_err_p, nonpcm_det, dtscd_det;
    logic       audio_bit, preemph_bit, qsub_chg_p, cstat_chg_p;
    logic       en_hold_we, en_direct_we, hold_we, status_rd;
    logic [1:0] clk_mode;
    logic [7:0] cfg_wdata, status;
    logic       int_hold, int_direct;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state, built from the requirements.
    logic [7:0] m_stat, m_ena, m_enb;
    logic [1:0] m_hold;
    int         m_cnt;

    always #4 clk = ~clk;

    rxirq_aggregator i_rxirq_aggregator (.*);

    function automatic int hold_len(input logic [1:0] h);
        return 512 << h;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        fs_tick = 0; lock_lost = 0; par_err_p = 0; nonpcm_det = 0; dtscd_det = 0;
        audio_bit = 0; preemph_bit = 0; qsub_chg_p = 0; cstat_chg_p = 0;
        en_hold_we = 0; en_direct_we = 0; hold_we = 0; status_rd = 0;
        clk_mode = 2'b00; cfg_wdata = 0;
    endtask

    // Advance one edge, update the reference, compare, return at negedge.
    task automatic step(input string tag);
        logic act_old, off_old;
        @(posedge clk);
        act_old = |(m_stat & m_ena);
        off_old = (clk_mode == 2'b01);
        if (off_old) m_cnt = 0;
        else if (act_old) m_cnt = hold_len(m_hold);
        else if (fs_tick && m_cnt != 0) m_cnt--;
        m_stat[0] = lock_lost;
        m_stat[2] = nonpcm_det;
        m_stat[3] = dtscd_det;
        if (!lock_lost) begin
            m_stat[4] = audio_bit;
            m_stat[5] = preemph_bit;
        end
        m_stat[1] = (m_stat[1] & ~status_rd) | par_err_p;
        m_stat[6] = (m_stat[6] & ~status_rd) | (qsub_chg_p & ~lock_lost);
        m_stat[7] = (m_stat[7] & ~status_rd) | (cstat_chg_p & ~lock_lost);
        if (en_hold_we) m_ena = cfg_wdata;
        if (en_direct_we) m_enb = cfg_wdata;
        if (hold_we) m_hold = cfg_wdata[1:0];
        #2;
        chk({tag, " status"}, status, m_stat);
        chk({tag, " int_direct"}, int_direct,
            (clk_mode != 2'b01) && (|(m_stat & m_enb)));
        chk({tag, " int_hold"}, int_hold,
            (clk_mode != 2'b01) && ((|(m_stat & m_ena)) || m_cnt != 0));
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt_hi;
        void'($urandom(32'h5eed_1234));
        idle();
        rst_n = 0;
        m_stat = 0; m_ena = 8'h03; m_enb = 8'h1C; m_hold = 2'b01; m_cnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status", status, 0);
        chk("R1 int_hold", int_hold, 0);
        chk("R1 int_direct", int_direct, 0);
        rst_n = 1;
        step("R1");

        // R2 / R6: live bits; non-PCM enabled on direct line by default.
        nonpcm_det = 1; step("R2");
        chk("R6 direct high", int_direct, 1);
        nonpcm_det = 0; step("R6");
        chk("R6 direct falls at once", int_direct, 0);

        // R3: sticky parity with simultaneous read keeps the bit.
        par_err_p = 1; step("R3"); par_err_p = 0;
        step("R3");
        chk("R3 parity sticky", status[1], 1);
        par_err_p = 1; status_rd = 1; step("R3");
        chk("R3 pulse beats read", status[1], 1);
        par_err_p = 0; step("R3");
        status_rd = 0; step("R3");
        chk("R3 read clears", status[1], 0);
        repeat (1100) begin fs_tick = 1; step("R7"); end
        fs_tick = 0;

        // R4: freeze while lock lost.
        audio_bit = 1; step("R4");
        lock_lost = 1; audio_bit = 0; qsub_chg_p = 1; cstat_chg_p = 1; step("R4");
        chk("R4 audio frozen", status[4], 1);
        chk("R4 qsub ignored", status[6], 0);
        qsub_chg_p = 0; cstat_chg_p = 0; lock_lost = 0; step("R4");
        chk("R4 audio resumes", status[4], 0);

        // R5 / R10: enable writes leave status unchanged.
        par_err_p = 1; step("R5"); par_err_p = 0;
        cfg_wdata = 8'h00; en_hold_we = 1; en_direct_we = 1; step("R5");
        en_hold_we = 0; en_direct_we = 0;
        chk("R5 status kept", status[1], 1);
        chk("R10 hold line disabled", int_hold | int_direct, 1'b1 & int_hold);
        status_rd = 1; step("R10"); status_rd = 0;
        repeat (1100) begin fs_tick = 1; step("R7"); end

        // R7: exact hold length with code 00, tick every cycle.
        cfg_wdata = 8'h01; en_hold_we = 1; step("R10");
        cfg_wdata = 8'h00; en_hold_we = 0; hold_we = 1; step("R10");
        hold_we = 0; fs_tick = 1;
        lock_lost = 1; step("R7");
        lock_lost = 0; cnt_hi = 0;
        for (int i = 0; i < 600; i++) begin
            step("R7");
            if (int_hold) cnt_hi++;
        end
        chk("R7 hold length 512", cnt_hi, 512);

        // R8: restart during hold.
        lock_lost = 1; step("R8"); lock_lost = 0;
        repeat (300) step("R8");
        lock_lost = 1; step("R8"); lock_lost = 0;
        cnt_hi = 0;
        for (int i = 0; i < 600; i++) begin
            step("R8");
            if (int_hold) cnt_hi++;
        end
        chk("R8 restart full length", cnt_hi, 512);

        // R9: PLL off forces low, clears hold, status untouched.
        lock_lost = 1; step("R9"); lock_lost = 0;
        clk_mode = 2'b01; step("R9");
        chk("R9 forced low", int_hold, 0);
        clk_mode = 2'b00; step("R9");
        chk("R9 hold cleared", int_hold, 0);
        fs_tick = 0;

        // Random phase.
        for (int i = 0; i < 20000; i++) begin
            idle();
            fs_tick     = ($urandom % 3) == 0;
            lock_lost   = ($urandom % 40) == 0;
            par_err_p   = ($urandom % 50) == 0;
            nonpcm_det  = ($urandom % 60) < 2;
            dtscd_det   = ($urandom % 70) == 0;
            audio_bit   = $urandom % 2;
            preemph_bit = $urandom % 2;
            qsub_chg_p  = ($urandom % 45) == 0;
            cstat_chg_p = ($urandom % 45) == 0;
            status_rd   = ($urandom % 20) == 0;
            clk_mode    = (($urandom % 100) == 0) ? 2'b01 : 2'($urandom % 4 | 2);
            cfg_wdata   = 8'($urandom);
            en_hold_we  = ($urandom % 300) == 0;
            en_direct_we = ($urandom % 300) == 0;
            hold_we     = ($urandom % 500) == 0;
            step("R2 R3 R4 R6 R7 R8 R9 R10 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule